// File: doc/BRIEF.md
# Masked-write open-drain line pair register

A single write/read register that gives software direct control over a clock line and a data line, so that a two-wire serial bus can be driven bit by bit from code. For each line the register holds a direction bit and an output-value bit. Each of these bits has its own write-enable mask bit in the same write word, so one write can move any subset of the four fields and leave the rest as they were.

The lines behave as open-drain. Software pulls a line low by making it an output with value zero. It lets the line go high by making it an input, after which the pad stops driving and the external pull-up raises the level. The level actually present on each pin is synchronised through two flops and can be read back whatever the direction setting. Two pull-up-disable bits, one per line, are kept as plain read/write storage. Bit-bang timing and the pads themselves are outside this block.

Bit map (word of 32 bits). Clock lane: bit 0 direction (1 = drive), bit 1 direction mask, bit 2 output value, bit 3 value mask, bit 4 sampled pin level. Data lane uses the same layout at bits 8 to 12. Bit 16 is the clock pull-up-disable bit and bit 17 the data pull-up-disable bit. Every other bit is reserved.

Top module: `gpair_od_reg`

## Requirements
- R1: After reset both direction bits are 0 (input), both output values are 0, both pull-up-disable bits are 0, and both output enables are low.
- R2: On a write, a line's direction bit (bit 0 / bit 8) takes the written value only when its mask bit (bit 1 / bit 9) is 1; a line's output value (bit 2 / bit 10) takes the written value only when its mask (bit 3 / bit 11) is 1; otherwise the field keeps its value.
- R3: A write that sets only a direction mask changes the direction and keeps the stored output value of that line.
- R4: A line whose direction bit is 0 has its output enable low, so the pad does not drive it.
- R5: A write with direction 1, value 0 and both masks set for a line leaves that line with output enable high and output value low.
- R6: Writes to one line's fields never change the other line's fields or pad outputs.
- R7: The sampled pin bit (bit 4 / bit 12) equals the pin level from two clock edges earlier, regardless of direction, and writes to it are ignored.
- R8: Mask bits (1, 3, 9, 11) always read as 0.
- R9: The pull-up-disable bits (16, 17) take the written value on every write, independently of the line masks and fields, and do not affect the pad outputs.
- R10: Reserved bits read as 0; the output value port of a line follows its stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_data | input | 32 | Write word with fields and mask bits |
| rd_data | output | 32 | Current register contents |
| ck_oe_o | output | 1 | Clock line pad output enable |
| ck_do_o | output | 1 | Clock line pad output value |
| ck_di_i | input | 1 | Clock line raw pin level |
| dt_oe_o | output | 1 | Data line pad output enable |
| dt_do_o | output | 1 | Data line pad output value |
| dt_di_i | input | 1 | Data line raw pin level |

## Verification
Every combination of the four field and mask bits on both lanes is applied in one sweep, with the stored state carried forward, so a design that ignores a mask, swaps the direction and value masks, or lets one lane's mask gate the other lane would show a wrong field or pad output. The pull-up bits are toggled across the same sweep to catch a design that gates them by a lane mask or loses them on a line write. Pin levels are changed on a driven and on a released line and read one and two edges later, which exposes a missing or extra synchroniser stage or a readback that shows the driven value instead of the pin. Writes that set the sampled-pin and mask positions check that those bits are neither stored nor echoed.

// File: rtl/gpair_pkg.sv
package gpair_pkg;
  localparam int LANES       = 2;
  localparam int LANE_STRIDE = 8;
  localparam int LANE_FLD_W  = 5;
  localparam int PU_BASE     = 16;

  localparam int F_DIR  = 0;
  localparam int F_DIRM = 1;
  localparam int F_VAL  = 2;
  localparam int F_VALM = 3;
  localparam int F_PIN  = 4;

  typedef struct packed {
    logic dir;
    logic val;
  } lane_st_t;

  typedef struct packed {
    logic dir;
    logic dir_m;
    logic val;
    logic val_m;
  } lane_wr_t;

  function automatic lane_wr_t unpack_wr(input logic [3:0] f);
    lane_wr_t r;
    r.dir   = f[F_DIR];
    r.dir_m = f[F_DIRM];
    r.val   = f[F_VAL];
    r.val_m = f[F_VALM];
    return r;
  endfunction
endpackage

// File: rtl/gpair_rst_sync.sv
module gpair_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpair_lane.sv
module gpair_lane
  import gpair_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [3:0]            wr_fld,
  input  logic                  pin_i,
  output logic                  oe_o,
  output logic                  do_o,
  output logic [LANE_FLD_W-1:0] rb_o
);
  lane_st_t st_q, st_d;
  lane_wr_t wr;
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic pin_s;

  assign wr = unpack_wr(wr_fld);

  always_comb begin
    st_d = st_q;
    if (wr_en) begin
      if (wr.dir_m) st_d.dir = wr.dir;
      if (wr.val_m) st_d.val = wr.val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  always_comb sync_d = {sync_q[SYNC_STAGES-2:0], pin_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= sync_d;
  end

  assign pin_s = sync_q[SYNC_STAGES-1];

  assign oe_o = st_q.dir;
  assign do_o = st_q.val;

  always_comb begin
    rb_o         = '0;
    rb_o[F_DIR]  = st_q.dir;
    rb_o[F_VAL]  = st_q.val;
    rb_o[F_PIN]  = pin_s;
  end
endmodule

// File: rtl/gpair_pullup.sv
module gpair_pullup #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [N-1:0] wr_bits,
  output logic [N-1:0] pu_o
);
  logic [N-1:0] pu_q, pu_d;

  always_comb pu_d = wr_en ? wr_bits : pu_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pu_q <= '0;
    else        pu_q <= pu_d;
  end

  assign pu_o = pu_q;
endmodule

// File: rtl/gpair_od_reg.sv
module gpair_od_reg
  import gpair_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              ck_oe_o,
  output logic              ck_do_o,
  input  logic              ck_di_i,
  output logic              dt_oe_o,
  output logic              dt_do_o,
  input  logic              dt_di_i
);
  localparam int PU_TOP = PU_BASE + LANES;

  logic rst_n_i;
  logic [LANES-1:0] oe, dout, din;
  logic [LANE_FLD_W-1:0] lane_rb [LANES];
  logic [LANES-1:0] pu;
  logic unused_wr;

  gpair_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  assign din[0] = ck_di_i;
  assign din[1] = dt_di_i;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    gpair_lane #(.SYNC_STAGES(SYNC_STAGES)) u_lane (
      .clk    (clk),
      .rst_n  (rst_n_i),
      .wr_en  (wr_en),
      .wr_fld (wr_data[l*LANE_STRIDE +: 4]),
      .pin_i  (din[l]),
      .oe_o   (oe[l]),
      .do_o   (dout[l]),
      .rb_o   (lane_rb[l])
    );
  end

  gpair_pullup #(.N(LANES)) u_pu (
    .clk(clk), .rst_n(rst_n_i), .wr_en(wr_en),
    .wr_bits(wr_data[PU_BASE +: LANES]), .pu_o(pu)
  );

  always_comb begin
    rd_data = '0;
    for (int l = 0; l < LANES; l++)
      rd_data[l*LANE_STRIDE +: LANE_FLD_W] = lane_rb[l];
    rd_data[PU_BASE +: LANES] = pu;
  end

  assign unused_wr = ^{wr_data[WORD_W-1:PU_TOP], wr_data[15:12], wr_data[7:4]};

  assign ck_oe_o = oe[0];
  assign ck_do_o = dout[0];
  assign dt_oe_o = oe[1];
  assign dt_do_o = dout[1];
endmodule

// File: rtl/gpair_od_chk.sv
module gpair_od_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [WORD_W-1:0] wr_data,
  input logic [WORD_W-1:0] rd_data,
  input logic              ck_oe_o,
  input logic              ck_do_o,
  input logic              ck_di_i,
  input logic              dt_oe_o,
  input logic              dt_do_o,
  input logic              dt_di_i
);
  logic [2:0] since_rst;
  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end
  assign armed = (since_rst >= 3'd5);

  a_r2_dir_gate: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (wr_en && !wr_data[1]) |=> $stable(ck_oe_o));
  a_r3_val_kept: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (wr_en && wr_data[1] && !wr_data[3]) |=> $stable(ck_do_o));
  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (wr_en && wr_data[1] && !wr_data[0]) |=> !ck_oe_o);
  a_r5_pull_low: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (wr_en && wr_data[1] && wr_data[0] && wr_data[3] && !wr_data[2]) |=> (ck_oe_o && !ck_do_o));
  a_r6_data_isolated: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (wr_en && !wr_data[9] && !wr_data[11]) |=> ($stable(dt_oe_o) && $stable(dt_do_o)));
  a_r7_pin_sync: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    (rd_data[4] == $past(ck_di_i, 2)) && (rd_data[12] == $past(dt_di_i, 2)));
  a_r8_masks_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rd_data[1], rd_data[3], rd_data[9], rd_data[11]}) == 0);
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    !wr_en |=> ($stable(ck_oe_o) && $stable(dt_oe_o) && $stable(ck_do_o) && $stable(dt_do_o)));
endmodule

bind gpair_od_reg gpair_od_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/sim_gpair_od_reg.sv
module sim_gpair_od_reg;
  logic clk = 1'b0;
  logic rst_n;
  logic wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic ck_oe_o, ck_do_o, dt_oe_o, dt_do_o;
  logic ck_di_i, dt_di_i;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [1:0] m_dir, m_val, m_pu, m_pin;

  always #2 clk = ~clk;

  gpair_od_reg u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ck_oe_o(ck_oe_o), .ck_do_o(ck_do_o), .ck_di_i(ck_di_i),
    .dt_oe_o(dt_oe_o), .dt_do_o(dt_do_o), .dt_di_i(dt_di_i)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_word();
    logic [31:0] w = '0;
    for (int l = 0; l < 2; l++) begin
      w[l*8 + 0] = m_dir[l];
      w[l*8 + 2] = m_val[l];
      w[l*8 + 4] = m_pin[l];
    end
    w[17:16] = m_pu;
    return w;
  endfunction

  task automatic apply(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
    for (int l = 0; l < 2; l++) begin
      if (w[l*8 + 1]) m_dir[l] = w[l*8 + 0];
      if (w[l*8 + 3]) m_val[l] = w[l*8 + 2];
    end
    m_pu = w[17:16];
  endtask

  task automatic check_all(input string req);
    chk(req, rd_data, model_word());
    chk(req, {28'd0, dt_oe_o, dt_do_o, ck_oe_o, ck_do_o},
        {28'd0, m_dir[1], m_val[1], m_dir[0], m_val[0]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    ck_di_i = 1'b1; dt_di_i = 1'b1;
    m_dir = '0; m_val = '0; m_pu = '0; m_pin = 2'b11;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1: reset state, R10 reserved zero
    check_all("R1");

    // R2 R6 R8 R9 R10: full sweep of both lanes' field/mask nibbles, pin bits written too
    for (int i = 0; i < 256; i++) begin
      logic [31:0] w;
      w = '0;
      w[3:0]   = i[3:0];
      w[11:8]  = i[7:4];
      w[4]     = i[0];
      w[12]    = ~i[1];
      w[17:16] = i[2:1] ^ i[6:5];
      w[31:18] = {14{i[3]}};
      w[7:5]   = {3{i[4]}};
      apply(w);
      check_all("R2");
    end

    // R5: pull clock low
    apply(32'h0000_000B);
    check_all("R5");
    chk("R5", {30'd0, ck_oe_o, ck_do_o}, 32'd2);

    // R3: direction-only write keeps value; set value 1 first then flip dir
    apply(32'h0000_000C);
    apply(32'h0000_0002);
    check_all("R3");
    chk("R3", {31'd0, ck_do_o}, 32'd1);

    // R4: release data line, R6 clock untouched
    apply(32'h0000_0B00);
    apply(32'h0000_0200);
    check_all("R4");
    chk("R4", {31'd0, dt_oe_o}, 32'd0);

    // R9: pull-up bits set then kept through line writes carrying them
    apply(32'h0003_0000);
    apply(32'h0003_0B0B);
    check_all("R9");
    chk("R9", {30'd0, ck_oe_o, dt_oe_o}, 32'd3);

    // R7: pin level two edges late, on driven clock line and released data line
    apply(32'h0000_0200);
    @(negedge clk);
    ck_di_i = 1'b0; dt_di_i = 1'b0;
    @(negedge clk);
    chk("R7", {30'd0, rd_data[12], rd_data[4]}, 32'd3);
    @(negedge clk);
    m_pin = 2'b00;
    check_all("R7");
    apply(32'h0000_1010);
    check_all("R7");
    @(negedge clk);
    ck_di_i = 1'b1;
    @(negedge clk);
    chk("R7", {31'd0, rd_data[4]}, 32'd0);
    @(negedge clk);
    m_pin = 2'b01;
    check_all("R7");

    // R8: all-mask write with fields clear, masks read zero
    apply(32'h0000_0A0A);
    check_all("R8");
    chk("R8", {28'd0, rd_data[11], rd_data[9], rd_data[3], rd_data[1]}, 32'd0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule